// File: doc/BRIEF.md
# Delayed Branch Sequencing Unit

This block generates the fetch address for a pipelined core whose unconditional branches are delayed. In each cycle the core presents decode information for the instruction at the current fetch address. That information says whether the instruction is an unconditional branch, whether the branch is PC-relative or register-indirect, its displacement, and the register value read for it. When the sequencer accepts a branch, it captures the target right away. It then lets exactly one more instruction run: the delay slot at the next sequential address. After that it redirects fetch to the captured target. The pipeline therefore never has to discard an instruction fetched behind a taken branch.

The core drives `advance` high in every cycle in which the current instruction retires. While `advance` is low the sequencer holds all of its state. Because the target is captured at the branch, a slot instruction that rewrites the target register cannot change where the branch goes. A branch found in a delay slot is not honoured. The block raises a one-cycle illegal-slot flag for it, and fetch still goes to the original target.

Top module: `slot_branch_sequencer`

## Requirements
- R1: While `rstN` is low at a rising clock edge, the next outputs are `fetchAddr` = `resetVec`, `inSlot` = 0 and `slotIllegal` = 0, and any pending branch is discarded.
- R2: When `advance` is 1, `inSlot` is 0 and `brValid` is 0, the next `fetchAddr` is the current `fetchAddr` + 2 (16-bit instruction words).
- R3: When `advance` is 0 and `inSlot` is 0, `fetchAddr` and `inSlot` keep their values, `slotIllegal` is 0 in the next cycle, and `brValid` is ignored.
- R4: When `advance` is 1, `inSlot` is 0 and `brValid` is 1, the branch is accepted. The next `fetchAddr` is the branch address + 2 (the delay slot) and the next `inSlot` is 1.
- R5: When `advance` is 1 and `inSlot` is 1, the next `fetchAddr` is the target captured at the branch and the next `inSlot` is 0. The redirect never happens earlier than this.
- R6: With `brKind` = 0 (PC-relative), the target is the branch address + 4 + (`brDisp` sign-extended from bit 11, times 2), computed modulo 2^32.
- R7: With `brKind` = 1 (register-indirect), the target is the `regValue` present in the cycle in which the branch is accepted. Any `regValue` presented during the slot does not change the target.
- R8: When `advance` is 1, `inSlot` is 1 and `brValid` is 1, `slotIllegal` is 1 for exactly the next cycle. Fetch still goes to the original target, and the next `inSlot` is 0.
- R9: When `advance` is 0 while `inSlot` is 1, the slot state and the captured target are held. The redirect happens on the first later cycle with `advance` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| resetVec | input | 32 | Fetch address loaded by reset |
| advance | input | 1 | Current instruction retires this cycle |
| brValid | input | 1 | Current instruction is an unconditional branch |
| brKind | input | 1 | 0 = PC-relative, 1 = register-indirect |
| brDisp | input | 12 | Signed displacement in instruction words |
| regValue | input | 32 | Register value read for a register-indirect branch |
| fetchAddr | output | 32 | Address of the current instruction |
| inSlot | output | 1 | Current instruction is a delay-slot instruction |
| slotIllegal | output | 1 | One-cycle flag: a branch was found in a delay slot |

## Verification
The sequencer is driven with a seeded random mix of retiring and stalled cycles, plain instructions, and branches of both kinds with random displacements and register values. This separates linear stepping from slot entry, redirect and hold. Directed cases use the most negative and most positive displacements and a displacement of -1 to expose sign-extension and scaling faults. A register-indirect branch whose `regValue` changes during the slot shows whether the target was captured early or read late. A branch placed in a slot, and a stall held across a slot, test the illegal-slot flag and whether the pending redirect is kept or lost.

// File: rtl/slot_seq_pkg.sv
package slot_seq_pkg;

  typedef enum logic {
    BR_PCREL = 1'b0,
    BR_REG   = 1'b1
  } brKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic stepSeq;     // advance to the next sequential word
    logic loadTarget;  // capture a branch target
    logic takeTarget;  // redirect fetch to the captured target
  } seqCtrl_t;

endpackage

// File: rtl/seq_control.sv
module seq_control
  import slot_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     advance,
  input  logic     brValid,
  output seqCtrl_t ctrl,
  output logic     inSlot,
  output logic     slotIllegal
);

  logic pendingQ;
  logic illegalQ;

  always_comb begin
    ctrl = '0;
    if (rstN && advance) begin
      if (pendingQ) begin
        ctrl.takeTarget = 1'b1;
      end else begin
        ctrl.stepSeq    = 1'b1;
        ctrl.loadTarget = brValid;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendingQ <= 1'b0;
      illegalQ <= 1'b0;
    end else begin
      illegalQ <= advance & pendingQ & brValid;
      if (advance) begin
        pendingQ <= pendingQ ? 1'b0 : brValid;
      end
    end
  end

  assign inSlot      = pendingQ;
  assign slotIllegal = illegalQ;

  // R8: a branch in the slot flags once and starts no new slot
  a_r8_slot_branch_flagged: assert property (@(posedge clk) disable iff (!rstN)
    (advance && pendingQ && brValid) |=> (slotIllegal && !inSlot));

  // R8: the flag is a single-cycle pulse
  a_r8_flag_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    slotIllegal |=> !slotIllegal);

  // R9: a stall inside the slot keeps the slot pending
  a_r9_slot_held_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !advance) |=> inSlot);

endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import slot_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DISP_W     = 12,
  parameter int WORD_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] resetVec,
  input  seqCtrl_t          ctrl,
  input  logic              brKind,
  input  logic [DISP_W-1:0] brDisp,
  input  logic [ADDR_W-1:0] regValue,
  output logic [ADDR_W-1:0] fetchAddr
);

  localparam int              DISP_SHIFT = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] PC_AHEAD = ADDR_W'(2 * WORD_BYTES);

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] targetQ;
  logic [ADDR_W-1:0] dispScaled;
  logic [ADDR_W-1:0] relTarget;
  logic [ADDR_W-1:0] nextTarget;

  generate
    if (DISP_W >= ADDR_W) begin : g_disp_wide
      assign dispScaled = ADDR_W'(brDisp) << DISP_SHIFT;
    end else begin : g_disp_sext
      assign dispScaled = {{(ADDR_W-DISP_W){brDisp[DISP_W-1]}}, brDisp} << DISP_SHIFT;
    end
  endgenerate

  assign relTarget  = pcQ + PC_AHEAD + dispScaled;
  assign nextTarget = (brKind == BR_REG) ? regValue : relTarget;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcQ <= resetVec;
    end else if (ctrl.takeTarget) begin
      pcQ <= targetQ;
    end else if (ctrl.stepSeq) begin
      pcQ <= pcQ + STEP;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      targetQ <= '0;
    end else if (ctrl.loadTarget) begin
      targetQ <= nextTarget;
    end
  end

  assign fetchAddr = pcQ;

  // R5: the redirect lands on the value captured earlier
  a_r5_redirect_to_captured: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.takeTarget |=> (pcQ == $past(targetQ)));

  // R7: without a capture strobe the target cannot move
  a_r7_target_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.loadTarget && $past(rstN)) |=> (targetQ == $past(targetQ)));

endmodule

// File: rtl/slot_branch_sequencer.sv
module slot_branch_sequencer
  import slot_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DISP_W     = 12,
  parameter int WORD_BYTES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] resetVec,
  input  logic              advance,
  input  logic              brValid,
  input  logic              brKind,
  input  logic [DISP_W-1:0] brDisp,
  input  logic [ADDR_W-1:0] regValue,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              inSlot,
  output logic              slotIllegal
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  seqCtrl_t ctrl;

  seq_control u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .advance     (advance),
    .brValid     (brValid),
    .ctrl        (ctrl),
    .inSlot      (inSlot),
    .slotIllegal (slotIllegal)
  );

  seq_datapath #(
    .ADDR_W     (ADDR_W),
    .DISP_W     (DISP_W),
    .WORD_BYTES (WORD_BYTES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .resetVec  (resetVec),
    .ctrl      (ctrl),
    .brKind    (brKind),
    .brDisp    (brDisp),
    .regValue  (regValue),
    .fetchAddr (fetchAddr)
  );

  // R2: plain retirement steps by one word
  a_r2_linear_step: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !inSlot && !brValid) |=> (fetchAddr == $past(fetchAddr) + STEP && !inSlot));

  // R3: no retirement, no movement
  a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !inSlot) |=> ($stable(fetchAddr) && !inSlot && !slotIllegal));

  // R4: an accepted branch enters its slot at the next word
  a_r4_enter_slot: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !inSlot && brValid) |=> (inSlot && fetchAddr == $past(fetchAddr) + STEP));

  // R5: the slot lasts exactly one retirement
  a_r5_slot_ends: assert property (@(posedge clk) disable iff (!rstN)
    (advance && inSlot) |=> !inSlot);

endmodule

// File: tb/slot_branch_sequencer_tb.sv
`timescale 1ns/1ps
module slot_branch_sequencer_tb_top;

  localparam int AW = 32;
  localparam int DW = 12;
  localparam logic [AW-1:0] VEC = 32'h0000_1000;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] resetVec;
  logic          advance;
  logic          brValid;
  logic          brKind;
  logic [DW-1:0] brDisp;
  logic [AW-1:0] regValue;
  logic [AW-1:0] fetchAddr;
  logic          inSlot;
  logic          slotIllegal;

  int checks = 0;
  int fails  = 0;

  // bench reference state
  logic [AW-1:0] mPc;
  logic          mSlot;
  logic [AW-1:0] mTgt;
  logic          mKind;
  logic          mIll;

  always #10 clk = ~clk;

  slot_branch_sequencer dut_i (
    .clk(clk), .rstN(rstN), .resetVec(resetVec), .advance(advance),
    .brValid(brValid), .brKind(brKind), .brDisp(brDisp), .regValue(regValue),
    .fetchAddr(fetchAddr), .inSlot(inSlot), .slotIllegal(slotIllegal)
  );

  function automatic logic [AW-1:0] relTgt(input logic [AW-1:0] pc, input logic [DW-1:0] d);
    logic signed [AW-1:0] sd;
    sd = AW'(signed'(d));
    return pc + 32'd4 + (sd <<< 1);
  endfunction

  task automatic step(input logic rst, input logic adv, input logic bv,
                      input logic kind, input logic [DW-1:0] disp,
                      input logic [AW-1:0] rv);
    string tag;
    rstN = rst; advance = adv; brValid = bv; brKind = kind;
    brDisp = disp; regValue = rv;
    if (!rst) begin
      tag = "R1"; mPc = resetVec; mSlot = 1'b0; mIll = 1'b0;
    end else if (!adv) begin
      tag = mSlot ? "R9" : "R3"; mIll = 1'b0;
    end else if (mSlot) begin
      tag = bv ? "R8" : (mKind ? "R5/R7" : "R5/R6");
      mPc = mTgt; mSlot = 1'b0; mIll = bv;
    end else if (bv) begin
      tag = "R4";
      mTgt = kind ? rv : relTgt(mPc, disp);
      mKind = kind; mPc = mPc + 32'd2; mSlot = 1'b1; mIll = 1'b0;
    end else begin
      tag = "R2"; mPc = mPc + 32'd2; mIll = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (fetchAddr !== mPc || inSlot !== mSlot || slotIllegal !== mIll) begin
      fails++;
      $display("FAIL %s: fetchAddr=%h inSlot=%b slotIllegal=%b expected %h %b %b",
               tag, fetchAddr, inSlot, slotIllegal, mPc, mSlot, mIll);
    end
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1234;
    void'($urandom(seed));
    resetVec = VEC; rstN = 1'b0; advance = 1'b0; brValid = 1'b0;
    brKind = 1'b0; brDisp = '0; regValue = '0;
    mPc = '0; mSlot = 1'b0; mTgt = '0; mKind = 1'b0; mIll = 1'b0;
    @(negedge clk);
    // R1 reset state, even with a branch and retirement offered
    step(1'b0, 1'b1, 1'b1, 1'b0, 12'h010, 32'h0);
    step(1'b0, 1'b0, 1'b0, 1'b0, 12'h000, 32'h0);
    // R2 linear stepping
    step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 32'h0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 32'h0);
    // R3 stall with a branch offered: ignored
    step(1'b1, 1'b0, 1'b1, 1'b0, 12'h7FF, 32'h0);
    // R4/R6 PC-relative with most positive displacement
    step(1'b1, 1'b1, 1'b1, 1'b0, 12'h7FF, 32'h0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 32'h0);
    // R6 most negative displacement
    step(1'b1, 1'b1, 1'b1, 1'b0, 12'h800, 32'h0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 32'h0);
    // R6 displacement of -1 word
    step(1'b1, 1'b1, 1'b1, 1'b0, 12'hFFF, 32'h0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 32'h0);
    // R7 register-indirect; slot rewrites the register value
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 32'h0000_4A00);
    step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 32'hDEAD_0000);
    // R9 stall inside the slot, then redirect
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 32'h0000_8000);
    step(1'b1, 1'b0, 1'b0, 1'b0, 12'h000, 32'h1111_1110);
    step(1'b1, 1'b0, 1'b1, 1'b1, 12'h000, 32'h2222_2220);
    step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 32'h3333_3330);
    // R8 branch in a slot: flagged, original target kept
    step(1'b1, 1'b1, 1'b1, 1'b0, 12'h020, 32'h0);
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 32'h5555_0000);
    step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 32'h0);
    // R1 reset while a slot is pending
    step(1'b1, 1'b1, 1'b1, 1'b1, 12'h000, 32'h0000_9000);
    resetVec = 32'h0000_2000;
    step(1'b0, 1'b1, 1'b0, 1'b0, 12'h000, 32'h0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 12'h000, 32'h0);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic a, b, k;
      a = ($urandom % 4) != 0;
      b = ($urandom % 10) < 3;
      k = $urandom % 2;
      step(1'b1, a, b, k, 12'($urandom), {$urandom} & 32'hFFFF_FFFE);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule